// File: doc/BRIEF.md
# SDRAM Refresh and Mode-Command Issuer

This block drives the housekeeping side of a memory port with one or two SDRAM devices. Software presents a mode-command request. The request carries a command code, a target bit for each device, a repeat count and a 13-bit mode-register value. The block checks the request against the targeting rules. A legal request is sequenced onto the SDRAM command pins, and the block waits the matching recovery delay after each command. An illegal request is dropped silently.

A free-running refresh timer runs alongside the command path. Each time it expires, the block precharges both devices and then auto-refreshes them. If the timer expires again while an earlier refresh is still waiting for service, a sticky error flag is set. This flag can raise an interrupt. Read and write traffic and row handling belong to another block.

A single sequencer executes both software requests and timer refreshes. The busy output is high while it is working, and a request presented during that time is lost.

Top module: `sdr_housekeeper`

## Requirements
- R1: After a synchronous active-low reset, both chip selects are high, RAS/CAS/WE are high, the address is zero, and busy, rf_err and irq are low.
- R2: A request with both req_tgt_a and req_tgt_b low is ignored: busy stays low and no command appears on the pins.
- R3: With dual_dev high, an auto-refresh or precharge-all request that does not set both target bits is ignored. Other codes may target one device.
- R4: Command codes are 001 = NOP, 010 = precharge-all, 011 = auto-refresh and 100 = load-mode. All other codes are ignored. The pin patterns {ras_n,cas_n,we_n} are 111, 010, 001 and 000 respectively. sd_cs_n[0] goes low for req_tgt_a and sd_cs_n[1] goes low for req_tgt_b. Each command lasts one cycle.
- R5: An auto-refresh request issues req_nrep+1 refresh commands (1 to 16). Consecutive refresh commands start exactly t_rc+2 cycles apart.
- R6: Load-mode drives sd_addr with req_mrv and is followed by t_mrd+1 idle busy cycles. Precharge-all drives sd_addr bit 10 high and all other bits low, and is followed by t_rp+1 idle busy cycles. NOP is followed by one idle busy cycle. For any other command, sd_addr is zero.
- R7: busy goes high in the cycle after an accepted request. It stays high for n*(d+2) cycles, where n is the command count and d is the delay that applies. A request presented while busy is high is dropped.
- R8: The refresh timer expires every max(rf_count,41)+1 cycles, so a programmed count below 41 behaves as 41.
- R9: A timer refresh sends precharge-all to both devices (sd_cs_n = 00), then auto-refresh to both devices t_rp+2 cycles later.
- R10: rf_err is set when the timer expires while an earlier timer refresh has not yet started. Once set, it stays high until rf_err_clr is sampled high. It never sets while timer refreshes are serviced on time.
- R11: irq is high exactly when rf_err and irq_en are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request strobe, one cycle |
| req_mode | input | 3 | Command code |
| req_tgt_a | input | 1 | Target device A |
| req_tgt_b | input | 1 | Target device B |
| req_nrep | input | 4 | Auto-refresh repeat count minus one |
| req_mrv | input | 13 | Mode-register value for load-mode |
| dual_dev | input | 1 | Two devices are fitted |
| rf_count | input | 13 | Refresh timer count |
| rf_err_clr | input | 1 | Clears the refresh error flag |
| irq_en | input | 1 | Interrupt enable for the refresh error |
| t_rc | input | 4 | Row-cycle delay after each refresh |
| t_mrd | input | 4 | Load-mode-to-active delay |
| t_rp | input | 4 | Precharge delay |
| sd_cs_n | output | 2 | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address lines |
| busy | output | 1 | Sequencer is executing a command |
| rf_err | output | 1 | Sticky refresh error |
| irq | output | 1 | Refresh error interrupt |

## Verification
The bench tests the targeting rules at their edges. It sends requests with no target, single-target refresh and precharge-all with two devices fitted, and an unused code. A filter that leaked any of these would produce a command pulse or a busy window where none is expected. Repeat counts of 1, 3 and 16 are measured cycle by cycle. An off-by-one in the repeat counter or the recovery wait would show up as a wrong command count, a wrong spacing or a wrong busy length. The timer is timed with a count above and below the 41-cycle floor; a design that skipped the clamp would refresh far too often. A long software refresh is used to starve the timer, which must set the sticky error and keep it set until it is cleared; it must not set it during normal servicing.

// File: rtl/sdr_hk_pkg.sv
// Shared types and codes for the SDRAM housekeeping block.
package sdr_hk_pkg;
    // Software command codes
    localparam logic [2:0] MC_NOP  = 3'b001;
    localparam logic [2:0] MC_PALL = 3'b010;
    localparam logic [2:0] MC_AREF = 3'b011;
    localparam logic [2:0] MC_LMR  = 3'b100;

    // Address bit that selects "all banks" during precharge
    localparam int PALL_BIT = 10;

    typedef enum logic [1:0] {OP_NOP, OP_PALL, OP_AREF, OP_LMR} op_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;
endpackage

// File: rtl/sdr_req_filter.sv
// Decodes a software command code and applies the targeting rules.
// Assumes: purely combinational, evaluated every cycle.
module sdr_req_filter
    import sdr_hk_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       tgt_a,
    input  logic       tgt_b,
    input  logic       dual,
    output logic       legal,
    output op_e        op
);
    // Map the code to an operation and reject illegal targeting
    always_comb begin
        legal = 1'b1;
        op    = OP_NOP;
        case (mode)
            MC_NOP:  op = OP_NOP;
            MC_PALL: op = OP_PALL;
            MC_AREF: op = OP_AREF;
            MC_LMR:  op = OP_LMR;
            default: legal = 1'b0;
        endcase
        if (!tgt_a && !tgt_b)
            legal = 1'b0;
        if (dual && (op == OP_PALL || op == OP_AREF) && !(tgt_a && tgt_b))
            legal = 1'b0;
    end
endmodule

// File: rtl/sdr_refresh_timer.sv
// Periodic refresh timer with a pending-request flag and a sticky error.
// Assumes: the count input is quasi-static; values below MIN_CNT are clamped.
module sdr_refresh_timer #(
    parameter int TMR_W   = 13,
    parameter int MIN_CNT = 41
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] count,
    input  logic             ack,
    input  logic             err_clr,
    output logic             pend,
    output logic             err
);
    localparam logic [TMR_W-1:0] FLOOR = TMR_W'(MIN_CNT);

    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] limit;
    logic             expire;

    assign limit  = (count < FLOOR) ? FLOOR : count;
    assign expire = (tmr >= limit);

    // Free-running up counter, wraps at the effective limit
    always_ff @(posedge clk) begin
        if (!rst_n)      tmr <= '0;
        else if (expire) tmr <= '0;
        else             tmr <= tmr + 1'b1;
    end

    // Pending refresh: raised on expiry, dropped when the sequencer starts it
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= expire | (pend & ~ack);
    end

    // Sticky error: expiry while the previous refresh is still waiting
    always_ff @(posedge clk) begin
        if (!rst_n)                        err <= 1'b0;
        else if (expire && pend && !ack)   err <= 1'b1;
        else if (err_clr)                  err <= 1'b0;
    end

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(pend));
endmodule

// File: rtl/sdr_cmd_seq.sv
// Command sequencer: issues one-cycle SDRAM commands and waits the matching
// recovery delay; timer refreshes run precharge-all then auto-refresh.
// Assumes: timing inputs are static while busy; pending timer refresh wins.
module sdr_cmd_seq
    import sdr_hk_pkg::*;
#(
    parameter int NDEV   = 2,
    parameter int ADDR_W = 13,
    parameter int REP_W  = 4,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend,
    input  logic              sw_ok,
    input  op_e               sw_op,
    input  logic [NDEV-1:0]   sw_cs,
    input  logic [REP_W-1:0]  sw_reps,
    input  logic [ADDR_W-1:0] sw_mrv,
    input  logic [DLY_W-1:0]  t_rc,
    input  logic [DLY_W-1:0]  t_mrd,
    input  logic [DLY_W-1:0]  t_rp,
    output logic              ack,
    output logic              busy,
    output logic [NDEV-1:0]   cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);
    st_e               state;
    op_e               cur_op;
    logic [NDEV-1:0]   cur_cs;
    logic [REP_W-1:0]  reps;
    logic [DLY_W-1:0]  cnt;
    logic [DLY_W-1:0]  dly;
    logic [ADDR_W-1:0] mrv;
    logic              chain;
    logic              issue;

    assign ack   = (state == ST_IDLE) && pend;
    assign busy  = (state != ST_IDLE);
    assign issue = (state == ST_ISSUE);

    // Recovery delay that follows the current operation
    always_comb begin
        case (cur_op)
            OP_PALL: dly = t_rp;
            OP_AREF: dly = t_rc;
            OP_LMR:  dly = t_mrd;
            default: dly = '0;
        endcase
    end

    // Sequencer state: start, issue, wait, repeat or chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_op <= OP_NOP;
            cur_cs <= '0;
            reps   <= '0;
            cnt    <= '0;
            mrv    <= '0;
            chain  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pend) begin
                        state  <= ST_ISSUE;
                        cur_op <= OP_PALL;
                        cur_cs <= '1;
                        reps   <= '0;
                        mrv    <= '0;
                        chain  <= 1'b1;
                    end else if (sw_ok) begin
                        state  <= ST_ISSUE;
                        cur_op <= sw_op;
                        cur_cs <= sw_cs;
                        reps   <= sw_reps;
                        mrv    <= sw_mrv;
                        chain  <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    state <= ST_WAIT;
                    cnt   <= dly;
                end
                default: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (reps != '0) begin
                        reps  <= reps - 1'b1;
                        state <= ST_ISSUE;
                    end else if (chain) begin
                        chain  <= 1'b0;
                        cur_op <= OP_AREF;
                        state  <= ST_ISSUE;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // One chip select per device, low only in the issue cycle
    for (genvar g = 0; g < NDEV; g++) begin : g_cs
        assign cs_n[g] = ~(issue & cur_cs[g]);
    end

    // Strobe pattern and address for the issued command
    always_comb begin
        {ras_n, cas_n, we_n} = 3'b111;
        addr = '0;
        if (issue) begin
            case (cur_op)
                OP_PALL: begin {ras_n, cas_n, we_n} = 3'b010; addr[PALL_BIT] = 1'b1; end
                OP_AREF: {ras_n, cas_n, we_n} = 3'b001;
                OP_LMR:  begin {ras_n, cas_n, we_n} = 3'b000; addr = mrv; end
                default: {ras_n, cas_n, we_n} = 3'b111;
            endcase
        end
    end

    // R5
    cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |=> (cs_n == '1));

    // R7
    busy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cs_n) == '1);
endmodule

// File: rtl/sdr_housekeeper.sv
// Top: SDRAM mode-command issuer and auto-refresh timer for two devices.
// Assumes: req_valid is a one-cycle strobe; requests while busy are lost.
module sdr_housekeeper
    import sdr_hk_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int REP_W   = 4,
    parameter int TMR_W   = 13,
    parameter int DLY_W   = 4,
    parameter int MIN_CNT = 41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic              req_tgt_a,
    input  logic              req_tgt_b,
    input  logic [REP_W-1:0]  req_nrep,
    input  logic [ADDR_W-1:0] req_mrv,
    input  logic              dual_dev,
    input  logic [TMR_W-1:0]  rf_count,
    input  logic              rf_err_clr,
    input  logic              irq_en,
    input  logic [DLY_W-1:0]  t_rc,
    input  logic [DLY_W-1:0]  t_mrd,
    input  logic [DLY_W-1:0]  t_rp,
    output logic [1:0]        sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              busy,
    output logic              rf_err,
    output logic              irq
);
    localparam int NDEV = 2;

    logic             legal;
    op_e              op;
    logic             pend;
    logic             ack;
    logic [REP_W-1:0] reps;

    assign reps = (op == OP_AREF) ? req_nrep : '0;
    assign irq  = rf_err & irq_en;

    sdr_req_filter u_filter (
        .mode  (req_mode),
        .tgt_a (req_tgt_a),
        .tgt_b (req_tgt_b),
        .dual  (dual_dev),
        .legal (legal),
        .op    (op)
    );

    sdr_refresh_timer #(.TMR_W(TMR_W), .MIN_CNT(MIN_CNT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (rf_count),
        .ack     (ack),
        .err_clr (rf_err_clr),
        .pend    (pend),
        .err     (rf_err)
    );

    sdr_cmd_seq #(.NDEV(NDEV), .ADDR_W(ADDR_W), .REP_W(REP_W), .DLY_W(DLY_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .sw_ok   (req_valid & legal),
        .sw_op   (op),
        .sw_cs   ({req_tgt_b, req_tgt_a}),
        .sw_reps (reps),
        .sw_mrv  (req_mrv),
        .t_rc    (t_rc),
        .t_mrd   (t_mrd),
        .t_rp    (t_rp),
        .ack     (ack),
        .busy    (busy),
        .cs_n    (sd_cs_n),
        .ras_n   (sd_ras_n),
        .cas_n   (sd_cas_n),
        .we_n    (sd_we_n),
        .addr    (sd_addr)
    );

    // R2
    no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !pend && req_valid && !req_tgt_a && !req_tgt_b) |=> !busy);

    // R9
    timer_pall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pend) |=> (sd_cs_n == 2'b00 && !sd_ras_n && sd_cas_n && !sd_we_n));
endmodule

// File: tb/sdr_housekeeper_tb.sv
module sdr_housekeeper_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_mode = '0;
    logic req_tgt_a = 1'b0, req_tgt_b = 1'b0;
    logic [3:0] req_nrep = '0;
    logic [12:0] req_mrv = '0;
    logic dual_dev = 1'b0;
    logic [12:0] rf_count = 13'd8191;
    logic rf_err_clr = 1'b0, irq_en = 1'b0;
    logic [3:0] t_rc = 4'd3, t_mrd = 4'd2, t_rp = 4'd1;
    logic [1:0] sd_cs_n;
    logic sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic busy, rf_err, irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sdr_housekeeper u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_tgt_a(req_tgt_a), .req_tgt_b(req_tgt_b), .req_nrep(req_nrep),
        .req_mrv(req_mrv), .dual_dev(dual_dev), .rf_count(rf_count),
        .rf_err_clr(rf_err_clr), .irq_en(irq_en), .t_rc(t_rc), .t_mrd(t_mrd),
        .t_rp(t_rp), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .busy(busy), .rf_err(rf_err), .irq(irq)
    );

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fields: mode[23:21] tgt_a[20] tgt_b[19] nrep[18:15] mrv[14:2] dual[1] accept[0]
    localparam int NV = 10;
    localparam logic [23:0] VECS [NV] = '{
        {3'b100, 1'b1, 1'b0, 4'd0,  13'h0123, 1'b0, 1'b1},
        {3'b011, 1'b1, 1'b1, 4'd2,  13'h0000, 1'b1, 1'b1},
        {3'b011, 1'b1, 1'b0, 4'd0,  13'h0000, 1'b1, 1'b0},
        {3'b010, 1'b0, 1'b1, 4'd0,  13'h0000, 1'b1, 1'b0},
        {3'b010, 1'b0, 1'b1, 4'd0,  13'h0000, 1'b0, 1'b1},
        {3'b100, 1'b0, 1'b0, 4'd0,  13'h0055, 1'b0, 1'b0},
        {3'b001, 1'b1, 1'b1, 4'd0,  13'h0000, 1'b1, 1'b1},
        {3'b110, 1'b1, 1'b1, 4'd0,  13'h0000, 1'b0, 1'b0},
        {3'b011, 1'b1, 1'b0, 4'd15, 13'h0000, 1'b0, 1'b1},
        {3'b100, 1'b1, 1'b1, 4'd0,  13'h1FFF, 1'b1, 1'b1}
    };

    function automatic int exp_pins(input logic [2:0] m);
        case (m)
            3'b010: return 3'b010;
            3'b011: return 3'b001;
            3'b100: return 3'b000;
            default: return 3'b111;
        endcase
    endfunction

    function automatic int exp_dly(input logic [2:0] m);
        case (m)
            3'b010: return int'(t_rp);
            3'b011: return int'(t_rc);
            3'b100: return int'(t_mrd);
            default: return 0;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(input int i);
        logic [23:0] v;
        int n, d, ncmd, nbusy, last, gapbad, fcs, fpins, faddr, m;
        v = VECS[i];
        @(negedge clk);
        req_mode = v[23:21]; req_tgt_a = v[20]; req_tgt_b = v[19];
        req_nrep = v[18:15]; req_mrv = v[14:2]; dual_dev = v[1];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        m = int'(v[23:21]);
        n = (v[23:21] == 3'b011) ? int'(v[18:15]) + 1 : 1;
        d = exp_dly(v[23:21]);
        ncmd = 0; nbusy = 0; last = -1; gapbad = 0; fcs = 3; fpins = 7; faddr = 0;
        for (int c = 0; c < 400; c++) begin
            if (!busy) break;
            nbusy++;
            if (sd_cs_n != 2'b11) begin
                if (ncmd == 0) begin
                    fcs = int'(sd_cs_n);
                    fpins = int'({sd_ras_n, sd_cas_n, sd_we_n});
                    faddr = int'(sd_addr);
                end
                if (last >= 0 && (c - last) != d + 2) gapbad++;
                last = c;
                ncmd++;
            end
            @(negedge clk);
        end
        if (v[0]) begin
            check($sformatf("R7 busy length vec%0d", i), nbusy, n * (d + 2));
            check($sformatf("R5 command count vec%0d", i), ncmd, n);
            check($sformatf("R5 spacing vec%0d", i), gapbad, 0);
            check($sformatf("R4 chip selects vec%0d", i), fcs, int'(~{v[19], v[20]} & 2'b11));
            check($sformatf("R4 strobes vec%0d code %0d", i, m), fpins, exp_pins(v[23:21]));
            check($sformatf("R6 address vec%0d", i), faddr,
                  (m == 4) ? int'(v[14:2]) : (m == 2) ? 32'h400 : 0);
        end else begin
            check($sformatf("R2 R3 ignored busy vec%0d", i), nbusy, 0);
            check($sformatf("R2 R3 ignored commands vec%0d", i), ncmd, 0);
        end
        // Quiet afterwards
        for (int c = 0; c < 4; c++) begin
            if (sd_cs_n != 2'b11 || busy) begin
                check($sformatf("R7 quiet after vec%0d", i), 1, 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    // Measure the gap between two timer precharge-all commands
    task automatic timer_period(input logic [12:0] cnt, input int exp, input string req);
        int p0, p1, aref_at;
        rf_count = cnt;
        do_reset();
        p0 = -1; p1 = -1; aref_at = -1;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (sd_cs_n == 2'b00 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b010) begin
                if (p0 < 0) p0 = c; else if (p1 < 0) p1 = c;
            end
            if (p0 >= 0 && aref_at < 0 && sd_cs_n == 2'b00 &&
                {sd_ras_n, sd_cas_n, sd_we_n} == 3'b001) aref_at = c;
            if (p1 >= 0) break;
        end
        check({req, " timer period"}, p1 - p0, exp);
        check("R9 refresh follows precharge", aref_at - p0, int'(t_rp) + 2);
        check("R10 no error on time", int'(rf_err), 0);
    endtask

    initial begin
        int ncmd, lmr_seen;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", int'(sd_cs_n), 3);
        check("R1 strobes", int'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
        check("R1 addr", int'(sd_addr), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 rf_err irq", int'({rf_err, irq}), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R7: a request while busy is dropped
        @(negedge clk);
        req_mode = 3'b011; req_tgt_a = 1'b1; req_tgt_b = 1'b0; req_nrep = 4'd3; dual_dev = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ncmd = 0; lmr_seen = 0;
        for (int c = 0; c < 60; c++) begin
            if (c == 2) begin
                req_mode = 3'b100; req_mrv = 13'h0AAA; req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            if (sd_cs_n != 2'b11) begin
                ncmd++;
                if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b000) lmr_seen++;
            end
            @(negedge clk);
        end
        check("R7 drop while busy count", ncmd, 4);
        check("R7 drop while busy no load-mode", lmr_seen, 0);

        // R8 timer period above and below the floor
        timer_period(13'd60, 61, "R8");
        timer_period(13'd10, 42, "R8 clamp");

        // R10 / R11 starve the timer with a long software refresh
        rf_count = 13'd41;
        t_rc = 4'd15;
        do_reset();
        @(negedge clk);
        req_mode = 3'b011; req_tgt_a = 1'b1; req_tgt_b = 1'b1; req_nrep = 4'd15; dual_dev = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (!busy) break;
            @(negedge clk);
        end
        check("R10 error set on stale refresh", int'(rf_err), 1);
        check("R11 irq masked", int'(irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R11 irq enabled", int'(irq), 1);
        repeat (60) @(negedge clk);
        check("R10 error sticky", int'(rf_err), 1);
        rf_err_clr = 1'b1;
        @(negedge clk);
        rf_err_clr = 1'b0;
        check("R10 error cleared", int'(rf_err), 0);
        check("R11 irq follows clear", int'(irq), 0);
        repeat (150) @(negedge clk);
        check("R10 stays clear", int'(rf_err), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule